// File: doc/BRIEF.md
# Prioritized Five-Source Interrupt Controller

This block sits beside a processor core and merges five interrupt request lines into one request. It presents a valid flag and a three-bit vector code for the most urgent eligible source. The sources use three trigger styles:

- **Non-maskable line:** needs a rising edge followed by a held high level.
- **Edge source:** its rising edge is captured in a sticky latch.
- **Three level sources:** these are sampled every clock and remembered for nothing.

The core steers the block through single-cycle strobes:

- **Enable and disable:** set and clear the global enable.
- **Mask write:** reloads the per-source masks and can also drop the edge latch.
- **Status read:** captures the mask and pending state.
- **Accept:** takes the request currently presented.

Accepting any request clears the global enable. Accepting the general-purpose source produces a one-cycle active-low acknowledge pulse. Decoding instructions, saving state and fetching the handler address belong to the core and are not part of this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The request codes are: non-maskable 4, edge source 3, level source A 2, level source B 1, general-purpose 0. When several sources are eligible, `irq_vec` shows the highest code. `irq_valid` is high exactly when some source is eligible. Both are driven only from registered state.
- R2: The non-maskable line becomes pending only when three conditions hold: a clock sample sees it high, the previous sample saw it low, and the next `NMI_HOLD` (default 2) samples also see it high. Pending shows after the last of those samples. A drop inside that window cancels the attempt. Holding the line high never retriggers.
- R3: A pending non-maskable request is presented whatever the global enable and the masks hold.
- R4: The edge latch sets on any sampled rising edge of `edge_in`, even while masked or disabled. It then stays set after the input falls, until it is cleared.
- R5: Level sources A, B and general-purpose are eligible from the previous clock's sample of their input only. Nothing is remembered after the input drops.
- R6: The global enable resets to 0. `cmd_enable` sets it. `cmd_disable` clears it, and wins over `cmd_enable` in the same cycle. Accepting any request clears it. Without the enable, only the non-maskable source is eligible.
- R7: `mask_wr` with `mask_data[3]`=1 loads the masks from `mask_data[2:0]`: bit 2 for the edge source, bit 1 for level A, bit 0 for level B. A 1 in a mask bit blocks that source. A mask write without bit 3 leaves the masks unchanged. Reset sets all three masks to 1. The general-purpose source has no mask.
- R8: `mask_wr` with `mask_data[4]`=1 clears the edge latch.
- R9: An accept taking code 0 drives `ext_ack_n` low for exactly the next cycle. An `accept` while `irq_valid` is low changes nothing.
- R10: Accepting code 4 clears the non-maskable pending flag. Accepting code 3 clears the edge latch, unless a new rising edge is sampled in the same cycle, in which case the latch stays set.
- R11: `status_rd` captures a word into `status`, which holds it until the next read. The bits are: bit 6 edge latch, bit 5 level A sample, bit 4 level B sample, bit 3 global enable, bits 2..0 the masks as in R7.
- R12: After reset, `irq_valid`=0, `ext_ack_n`=1 and `status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request line |
| edge_in | input | 1 | Edge-captured request line |
| lvl_a_in | input | 1 | Level request A |
| lvl_b_in | input | 1 | Level request B |
| ext_in | input | 1 | General-purpose level request |
| cmd_enable | input | 1 | Set global enable |
| cmd_disable | input | 1 | Clear global enable |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 5 | Mask write data (R7, R8) |
| status_rd | input | 1 | Status capture strobe |
| accept | input | 1 | Core takes the presented request |
| irq_valid | output | 1 | A request is presented |
| irq_vec | output | 3 | Code of the presented request |
| ext_ack_n | output | 1 | Active-low acknowledge for the general-purpose source |
| status | output | 7 | Captured status word (R11) |

## Verification
The collision that matters most is an accept that takes the edge source in the same cycle that a fresh rising edge arrives on `edge_in`. One cycle asks to clear the latch and the other to set it.

The bench provokes this directly. It releases the input for one cycle and raises it again together with `accept`. It then reads status and expects the latch still set with the enable cleared.

The random phase also produces accepts that meet non-maskable qualification, mask writes and enable/disable pairs. Every clock is judged against a behavioural model that applies the new-event-wins rule on its own.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int VEC_W = $clog2(NSRC);
  localparam int NLVL  = 3;
  localparam int MSK_W = 3;
  localparam int STA_W = 7;

  localparam logic [VEC_W-1:0] VEC_EXT  = 3'd0;
  localparam logic [VEC_W-1:0] VEC_LB   = 3'd1;
  localparam logic [VEC_W-1:0] VEC_LA   = 3'd2;
  localparam logic [VEC_W-1:0] VEC_EDGE = 3'd3;
  localparam logic [VEC_W-1:0] VEC_NMI  = 3'd4;

  // mask write field positions
  localparam int MD_SET = 3;
  localparam int MD_CLR = 4;

  // highest set bit wins
  function automatic logic [VEC_W-1:0] pick_vec(input logic [NSRC-1:0] elig);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i]) r = VEC_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_nmi_qual.sv
module irq_nmi_qual #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic clr,
  output logic pend
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic             prev_q;
  logic             arm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             done;

  assign rise = line_in && !prev_q;
  assign done = arm_q && line_in && (cnt_q == CNT_W'(HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= line_in;
      if (rise) begin
        arm_q <= 1'b1;
        cnt_q <= '0;
      end else if (arm_q) begin
        if (!line_in || done) begin
          arm_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (done) pend <= 1'b1;
    else if (clr)  pend <= 1'b0;
  end
endmodule

// File: rtl/irq_edge_catch.sv
module irq_edge_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic clr_take,
  input  logic clr_sw,
  output logic pend
);
  logic prev_q;
  logic rise;

  assign rise = line_in && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= line_in;
      if (rise)                  pend <= 1'b1;
      else if (clr_take || clr_sw) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  elig,
  output logic             valid,
  output logic [VEC_W-1:0] vec
);
  assign valid = |elig;
  assign vec   = pick_vec(elig);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NMI_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_in,
  input  logic             edge_in,
  input  logic             lvl_a_in,
  input  logic             lvl_b_in,
  input  logic             ext_in,
  input  logic             cmd_enable,
  input  logic             cmd_disable,
  input  logic             mask_wr,
  input  logic [4:0]       mask_data,
  input  logic             status_rd,
  input  logic             accept,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec,
  output logic             ext_ack_n,
  output logic [STA_W-1:0] status
);
  // level samples: [0] general-purpose, [1] level B, [2] level A
  logic [NLVL-1:0]  lvl_raw;
  logic [NLVL-1:0]  lvl_q;
  logic [MSK_W-1:0] mask_q;
  logic             ie_q;
  logic             nmi_pend;
  logic             edge_pend;
  logic [NSRC-1:0]  elig;
  logic             take;
  logic             take_nmi;
  logic             take_edge;
  logic             take_ext;
  logic             clr_edge_sw;
  logic             mask_set_en;

  assign lvl_raw = {lvl_a_in, lvl_b_in, ext_in};

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl_raw[g];
    end
  end

  irq_nmi_qual #(.HOLD(NMI_HOLD)) u_nmi (
    .clk(clk), .rst_n(rst_n), .line_in(nmi_in), .clr(take_nmi), .pend(nmi_pend)
  );

  irq_edge_catch u_edge (
    .clk(clk), .rst_n(rst_n), .line_in(edge_in),
    .clr_take(take_edge), .clr_sw(clr_edge_sw), .pend(edge_pend)
  );

  assign elig[VEC_NMI]  = nmi_pend;
  assign elig[VEC_EDGE] = edge_pend & ~mask_q[2] & ie_q;
  assign elig[VEC_LA]   = lvl_q[2]  & ~mask_q[1] & ie_q;
  assign elig[VEC_LB]   = lvl_q[1]  & ~mask_q[0] & ie_q;
  assign elig[VEC_EXT]  = lvl_q[0]  & ie_q;

  irq_prio_sel u_sel (.elig(elig), .valid(irq_valid), .vec(irq_vec));

  assign take        = accept && irq_valid;
  assign take_nmi    = take && (irq_vec == VEC_NMI);
  assign take_edge   = take && (irq_vec == VEC_EDGE);
  assign take_ext    = take && (irq_vec == VEC_EXT);
  assign clr_edge_sw = mask_wr && mask_data[MD_CLR];
  assign mask_set_en = mask_wr && mask_data[MD_SET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ie_q <= 1'b0;
    else if (take || cmd_disable) ie_q <= 1'b0;
    else if (cmd_enable)          ie_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mask_q <= '1;
    else if (mask_set_en) mask_q <= mask_data[MSK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_ack_n <= 1'b1;
    else        ext_ack_n <= ~take_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= '0;
    else if (status_rd) status <= {edge_pend, lvl_q[2], lvl_q[1], ie_q, mask_q};
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       nmi_in,
  input logic       irq_valid,
  input logic [2:0] irq_vec,
  input logic       ext_ack_n,
  input logic       nmi_pend,
  input logic       edge_pend,
  input logic       ie_q,
  input logic [2:0] mask_q,
  input logic       take_edge,
  input logic       clr_edge_sw,
  input logic       mask_set_en
);
  // R1 R3
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (irq_valid && irq_vec == 3'd4));

  // R2
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> ($past(nmi_in) && $past(nmi_in, 2)));

  // R4
  edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pend && !take_edge && !clr_edge_sw) |=> edge_pend);

  // R6
  take_drops_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && irq_valid) |=> !ie_q);

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_set_en |=> $stable(mask_q));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ack_n |=> ext_ack_n);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .nmi_in(nmi_in),
  .irq_valid(irq_valid), .irq_vec(irq_vec), .ext_ack_n(ext_ack_n),
  .nmi_pend(nmi_pend), .edge_pend(edge_pend), .ie_q(ie_q), .mask_q(mask_q),
  .take_edge(take_edge), .clr_edge_sw(clr_edge_sw), .mask_set_en(mask_set_en)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 2;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_in = 0, edge_in = 0, lvl_a_in = 0, lvl_b_in = 0, ext_in = 0;
  logic cmd_enable = 0, cmd_disable = 0, mask_wr = 0, status_rd = 0, accept = 0;
  logic [4:0] mask_data = '0;
  logic       irq_valid;
  logic [2:0] irq_vec;
  logic       ext_ack_n;
  logic [6:0] status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.NMI_HOLD(HOLD)) u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .edge_in(edge_in),
    .lvl_a_in(lvl_a_in), .lvl_b_in(lvl_b_in), .ext_in(ext_in),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .mask_wr(mask_wr),
    .mask_data(mask_data), .status_rd(status_rd), .accept(accept),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .ext_ack_n(ext_ack_n), .status(status)
  );

  // ---------------- behavioural reference model ----------------
  int       m_run;
  bit       m_nmi, m_nmi_prev, m_edge, m_edge_prev, m_ie, m_la, m_lb, m_ex, m_ack_n;
  bit [2:0] m_mask;
  bit [6:0] m_stat;

  function automatic int m_pick();
    if (m_nmi) return 4;
    if (!m_ie) return -1;
    if (m_edge && !m_mask[2]) return 3;
    if (m_la && !m_mask[1]) return 2;
    if (m_lb && !m_mask[0]) return 1;
    if (m_ex) return 0;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = -1; m_nmi = 0; m_nmi_prev = 0; m_edge = 0; m_edge_prev = 0;
      m_ie = 0; m_la = 0; m_lb = 0; m_ex = 0; m_ack_n = 1; m_mask = 3'b111; m_stat = '0;
    end else begin
      int  sel;
      bit  tk;
      sel = m_pick();
      tk  = accept && (sel >= 0);
      if (status_rd) m_stat = {m_edge, m_la, m_lb, m_ie, m_mask};
      m_ack_n = !(tk && sel == 0);
      if (tk || cmd_disable) m_ie = 0;
      else if (cmd_enable) m_ie = 1;
      if (mask_wr && mask_data[3]) m_mask = mask_data[2:0];
      if (edge_in && !m_edge_prev) m_edge = 1;
      else if ((tk && sel == 3) || (mask_wr && mask_data[4])) m_edge = 0;
      m_edge_prev = edge_in;
      if (tk && sel == 4) m_nmi = 0;
      if (nmi_in && !m_nmi_prev) m_run = 0;
      else if (m_run >= 0) begin
        if (!nmi_in) m_run = -1;
        else begin
          m_run++;
          if (m_run == HOLD) begin m_nmi = 1; m_run = -1; end
        end
      end
      m_nmi_prev = nmi_in;
      m_la = lvl_a_in; m_lb = lvl_b_in; m_ex = ext_in;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int sel;
      sel = m_pick();
      checks++;
      if (irq_valid !== (sel >= 0) || (sel >= 0 && irq_vec !== 3'(sel))) begin
        errors++;
        $display("FAIL R1 model: valid/vec %0b/%0d expected %0b/%0d", irq_valid, irq_vec, sel >= 0, sel);
      end
      checks++;
      if (ext_ack_n !== m_ack_n) begin
        errors++;
        $display("FAIL R9 model: ext_ack_n %0b expected %0b", ext_ack_n, m_ack_n);
      end
      checks++;
      if (status !== m_stat) begin
        errors++;
        $display("FAIL R11 model: status %b expected %b", status, m_stat);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_mask(input logic [4:0] d);
    mask_wr = 1; mask_data = d; step(); mask_wr = 0; mask_data = '0;
  endtask

  task automatic read_status();
    status_rd = 1; step(); status_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    // R12 reset state
    chk("R12 valid", irq_valid, 0);
    chk("R12 ack_n", ext_ack_n, 1);
    chk("R12 status", status, 0);
    read_status();
    chk("R7 reset masks in status", status, 7'b0000111);

    // R6 / R5 / R7 level source B
    lvl_b_in = 1; step();
    chk("R6 no enable", irq_valid, 0);
    cmd_enable = 1; step(); cmd_enable = 0;
    chk("R7 masked B", irq_valid, 0);
    pulse_mask(5'b01000);
    chk("R7 unmasked B valid", irq_valid, 1);
    chk("R7 unmasked B vec", irq_vec, 1);
    lvl_b_in = 0; step();
    chk("R5 level gone", irq_valid, 0);

    // R1 priority, R4 edge latch
    ext_in = 1; lvl_a_in = 1; lvl_b_in = 1; step();
    chk("R1 A over B and ext", irq_vec, 2);
    edge_in = 1; step();
    chk("R4 edge captured", irq_vec, 3);
    edge_in = 0; step(); step();
    chk("R4 edge held", irq_vec, 3);
    pulse_mask(5'b01100);
    chk("R7 edge masked", irq_vec, 2);
    read_status();
    chk("R4 latch while masked", status[6], 1);
    pulse_mask(5'b10000);
    read_status();
    chk("R8 latch cleared", status[6], 0);
    chk("R7 masks unchanged", status[2:0], 3'b100);

    // R6 accept clears enable
    accept = 1; step(); accept = 0;
    chk("R6 accept clears enable", irq_valid, 0);
    chk("R9 no ack for code 2", ext_ack_n, 1);

    // R2 / R3 non-maskable with enable off
    nmi_in = 1; step();
    chk("R2 edge sample", irq_valid, 0);
    step();
    chk("R2 first hold", irq_valid, 0);
    step();
    chk("R3 nmi valid", irq_valid, 1);
    chk("R3 nmi vec", irq_vec, 4);
    accept = 1; step(); accept = 0;
    chk("R10 nmi cleared", irq_valid, 0);
    step(); step(); step();
    chk("R2 no retrigger", irq_valid, 0);
    nmi_in = 0; step(); nmi_in = 1; step(); nmi_in = 0; step(); step(); step();
    chk("R2 short pulse", irq_valid, 0);

    // R9 acknowledge pulse
    lvl_a_in = 0; lvl_b_in = 0; ext_in = 1; cmd_enable = 1; step(); cmd_enable = 0;
    chk("R9 ext valid", irq_vec, 0);
    accept = 1; step(); accept = 0;
    chk("R9 ack low", ext_ack_n, 0);
    step();
    chk("R9 ack one cycle", ext_ack_n, 1);
    accept = 1; step(); accept = 0;
    chk("R9 accept ignored", ext_ack_n, 1);

    // R10 accept meets fresh edge
    ext_in = 0; pulse_mask(5'b01000);
    cmd_enable = 1; edge_in = 1; step(); cmd_enable = 0;
    chk("R10 edge presented", irq_vec, 3);
    edge_in = 0; step();
    accept = 1; edge_in = 1; step(); accept = 0;
    read_status();
    chk("R10 latch kept by new edge", status[6], 1);
    chk("R10 enable cleared", status[3], 0);
    cmd_enable = 1; step(); cmd_enable = 0;
    accept = 1; step(); accept = 0;
    read_status();
    chk("R10 latch cleared by accept", status[6], 0);

    // R6 disable wins
    ext_in = 1; cmd_enable = 1; cmd_disable = 1; step();
    cmd_enable = 0; cmd_disable = 0;
    chk("R6 disable dominates", irq_valid, 0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      nmi_in      = ($urandom_range(0, 7) != 0) ? nmi_in : ~nmi_in;
      edge_in     = $urandom_range(0, 1);
      lvl_a_in    = $urandom_range(0, 1);
      lvl_b_in    = $urandom_range(0, 1);
      ext_in      = $urandom_range(0, 1);
      cmd_enable  = ($urandom_range(0, 3) == 0);
      cmd_disable = ($urandom_range(0, 9) == 0);
      mask_wr     = ($urandom_range(0, 7) == 0);
      mask_data   = 5'($urandom_range(0, 31));
      status_rd   = ($urandom_range(0, 2) == 0);
      accept      = ($urandom_range(0, 2) == 0);
      step();
    end
    accept = 0; mask_wr = 0; status_rd = 0; cmd_enable = 0; cmd_disable = 0;

    // R12 reset mid-run
    rst_n = 0; step();
    chk("R12 reset valid", irq_valid, 0);
    chk("R12 reset status", status, 0);
    rst_n = 1; step();
    finish_run();
  end
endmodule